// File: doc/BRIEF.md
# Programmable Interval Timer with Latched Interrupt

This block is one countdown timer channel. It advances only on cycles where the 1 MHz tick enable is high. Software controls it through two word-wide locations on a simple strobe bus. The control word holds three things: a run flag, a repeat flag and a 29-bit count. The status word gives back the remaining count, and a write to it with one bit set acknowledges the interrupt.

When software loads a count of N, the channel expires after N+1 ticks. So a delay of C ticks is programmed as C-1, and a request for 0 or 1 tick is programmed as 0. In one-shot operation an expiry raises the interrupt and then drops the run flag, so the counter halts at zero. In repeat operation the counter reloads N on each expiry and fires every N+1 ticks; for example, a count of 9999 gives a 10 ms period at 1 MHz. The interrupt is a level output and stays high until software acknowledges it.

Top module: `interval_timer`

## Requirements
- R1: After reset the interrupt is low, the channel is stopped, and both read locations return 0.
- R2: The control word sits at address 0. Bit 31 is run, bit 30 is repeat, and bits 28:0 are the count. Bit 29 is ignored and reads as 0. Reading address 0 returns the current run and repeat flags and the stored count.
- R3: Every control write copies its count field into the live counter at once, discarding any count in progress, and takes priority over a tick in the same cycle.
- R4: With run set and a loaded count N, the interrupt rises on the clock edge that takes the (N+1)th tick after the load. It is low after only N ticks.
- R5: In one-shot mode (repeat clear), expiry clears the run flag. Further ticks leave the remaining count at 0 and raise no new expiry.
- R6: In repeat mode, expiry reloads N and the channel expires again after every further N+1 ticks.
- R7: A control write with run clear stops the channel. No interrupt follows, however many ticks arrive.
- R8: The interrupt stays high until a write to address 1 with bit 30 set. A write to address 1 with bit 30 clear leaves it high.
- R9: If an expiry and an acknowledge fall in the same cycle, the expiry wins and the interrupt stays high.
- R10: Reading address 1 returns the remaining count in bits 28:0 and 0 in all other bits. The count changes only on cycles with the tick enable high.
- R11: The largest count, 0x1FFFFFFF, is accepted and counts down by one per tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | 1 MHz count enable, one cycle wide |
| wr_en | input | 1 | Write strobe |
| addr | input | 1 | Word select: 0 control, 1 status |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the word selected by addr (combinational) |
| irq | output | 1 | Level interrupt |

## Verification
Every state element is one register deep. A write or tick applied in one cycle therefore shows on rdata and irq right after the next rising edge. The bench drives inputs and samples outputs on falling edges, so each check looks at the cycle after its stimulus. For each count in a sweep, the interrupt is sampled after exactly N ticks (it must be low) and again after tick N+1 (it must be high). Repeat mode is checked over several consecutive periods. The same-cycle expiry-and-acknowledge case is checked in the single cycle where the count is already zero.

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 29,
  parameter int RUN_BIT = 31,
  parameter int REP_BIT = 30,
  parameter int ACK_BIT = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic             run, rep;
  logic [CNT_W-1:0] cnt, reload;

  wire ctl_wr = wr_en && !addr;
  wire ack_wr = wr_en && addr && wdata[ACK_BIT];
  wire at_end = (cnt == ZERO);
  wire expire = run && tick && at_end && !ctl_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run    <= 1'b0;
      rep    <= 1'b0;
      cnt    <= '0;
      reload <= '0;
    end else if (ctl_wr) begin
      run    <= wdata[RUN_BIT];
      rep    <= wdata[REP_BIT];
      reload <= wdata[CNT_W-1:0];
      cnt    <= wdata[CNT_W-1:0];
    end else if (run && tick) begin
      if (!at_end)  cnt <= cnt - 1'b1;
      else if (rep) cnt <= reload;
      else          run <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      irq <= 1'b0;
    else if (expire) irq <= 1'b1;
    else if (ack_wr) irq <= 1'b0;
  end

  logic [DATA_W-1:0] ctl_view, sts_view;
  always_comb begin
    ctl_view = '0;
    ctl_view[RUN_BIT] = run;
    ctl_view[REP_BIT] = rep;
    ctl_view[CNT_W-1:0] = reload;
    sts_view = '0;
    sts_view[CNT_W-1:0] = cnt;
  end

  assign rdata = addr ? sts_view : ctl_view;
endmodule

// File: rtl/interval_timer_chk.sv
module interval_timer_chk #(
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 29,
  parameter int RUN_BIT = 31,
  parameter int ACK_BIT = 30
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              wr_en,
  input logic              addr,
  input logic [DATA_W-1:0] wdata,
  input logic              irq,
  input logic              run,
  input logic              rep,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  reload
);
  wire ctl_wr = wr_en && !addr;
  wire ack_wr = wr_en && addr && wdata[ACK_BIT];

  a_r3_load_now: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> cnt == $past(wdata[CNT_W-1:0]));

  a_r4_expiry_raises: assert property (@(posedge clk) disable iff (!rst_n)
    run && tick && cnt == '0 && !ctl_wr |=> irq);

  a_r5_oneshot_halts: assert property (@(posedge clk) disable iff (!rst_n)
    run && !rep && tick && cnt == '0 && !ctl_wr |=> !run);

  a_r6_periodic_reload: assert property (@(posedge clk) disable iff (!rst_n)
    run && rep && tick && cnt == '0 && !ctl_wr |=> run && cnt == $past(reload));

  a_r7_stop: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && !wdata[RUN_BIT] |=> !run);

  a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !ack_wr |=> irq);

  a_r10_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !ctl_wr |=> $stable(cnt));
endmodule

bind interval_timer interval_timer_chk #(
  .DATA_W(DATA_W), .CNT_W(CNT_W), .RUN_BIT(RUN_BIT), .ACK_BIT(ACK_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .irq(irq), .run(run), .rep(rep), .cnt(cnt), .reload(reload)
);

// File: tb/sim_interval_timer.sv
module sim_interval_timer;
  localparam int CLK_P = 10;
  localparam logic [31:0] RUN = 32'h8000_0000;
  localparam logic [31:0] REP = 32'h4000_0000;
  localparam logic [31:0] ACK = 32'h4000_0000;

  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0, addr = 0;
  logic [31:0] wdata = '0, rdata;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 0;

  interval_timer u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
                     .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #(CLK_P/2) clk = ~clk;

  task automatic step(); @(negedge clk); endtask

  task automatic wr(input logic a, input logic [31:0] d);
    wr_en = 1; addr = a; wdata = d; step(); wr_en = 0; wdata = '0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin tick = 1; step(); tick = 0; end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic a, input string req, input logic [31:0] exp);
    addr = a; #1; chk(req, rdata, exp);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 0);
    rd(0, "R1 ctl", 0);
    rd(1, "R1 sts", 0);
    rst_n = 1; step();

    // R4 R5 one-shot sweep
    for (int n = 0; n <= 20; n++) begin
      wr(0, RUN | n);
      rd(1, "R3 loaded", n);
      ticks(n);
      chk("R4 early", {31'b0, irq}, 0);
      rd(1, "R10 remaining", 0);
      ticks(1);
      chk("R4 expiry", {31'b0, irq}, 1);
      rd(0, "R5 run cleared", n);
      ticks(3);
      rd(1, "R5 halted", 0);
      wr(1, ACK);
      chk("R8 ack", {31'b0, irq}, 0);
      ticks(2);
      chk("R5 no refire", {31'b0, irq}, 0);
    end

    // R6 periodic
    wr(0, RUN | REP | 3);
    rd(0, "R2 ctl view", RUN | REP | 3);
    for (int p = 0; p < 4; p++) begin
      ticks(3);
      chk("R6 before", {31'b0, irq}, 0);
      rd(1, "R6 at zero", 0);
      ticks(1);
      chk("R6 period", {31'b0, irq}, 1);
      rd(1, "R6 reload", 3);
      wr(1, ACK);
    end
    wr(0, 0);

    // R8 ack without bit 30, R9 same-cycle race
    wr(0, RUN | 2);
    ticks(2);
    rd(1, "R9 setup", 0);
    tick = 1; wr(1, ACK); tick = 0;
    chk("R9 expiry wins", {31'b0, irq}, 1);
    wr(1, 32'h0000_0001);
    chk("R8 no-ack write", {31'b0, irq}, 1);
    wr(1, ACK);
    chk("R8 cleared", {31'b0, irq}, 0);

    // R3 reload mid-count
    wr(0, RUN | 10);
    ticks(4);
    rd(1, "R10 partial", 6);
    wr(0, RUN | 2);
    rd(1, "R3 discard", 2);
    ticks(2);
    chk("R3 early", {31'b0, irq}, 0);
    ticks(1);
    chk("R3 expiry", {31'b0, irq}, 1);
    wr(1, ACK);

    // R3 write beats tick
    wr(0, RUN | 5);
    tick = 1; wr(0, RUN | 8); tick = 0;
    rd(1, "R3 priority", 8);

    // R7 stop
    wr(0, RUN | 5);
    ticks(3);
    wr(0, 0);
    ticks(10);
    chk("R7 no irq", {31'b0, irq}, 0);
    rd(0, "R7 ctl", 0);
    rd(1, "R7 sts", 0);

    // R10 no tick no change
    wr(0, RUN | 7);
    repeat (5) step();
    rd(1, "R10 hold", 7);

    // R11 max, R2 bit 29 ignored
    wr(0, 32'hFFFF_FFFF);
    rd(0, "R2 bit29", 32'hDFFF_FFFF);
    rd(1, "R11 max", 32'h1FFF_FFFF);
    ticks(1);
    rd(1, "R11 dec", 32'h1FFF_FFFE);
    wr(0, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule